// File: doc/BRIEF.md
# Wake Event Latch Unit

This unit gathers wake-up events while a chip sits in a low-power state. Its sources come in two independent groups of equal width. One group takes internal peripheral event lines and the other takes external pins. Each source has its own selectable edge. Once that edge arrives, the unit keeps a sticky record of the event until software clears it. A per-source enable decides whether the record may wake the chip. The single wake request goes high whenever any enabled source holds a recorded event, in either group.

Every source passes through a two-flop synchroniser and then an edge detector. A simple single-cycle register port gives access to the registers. Writes take effect on the clock edge on which they are presented. Reads are combinational from the current register state. The address is three bits wide. The top bit picks the group: 0 is internal, 1 is pins. The low two bits pick the register: 0 enable, 1 polarity, 2 latched events (read, write-1-to-clear), 3 enabled events (read only).

Top module: `wake_latch_unit`

## Requirements
- R1: After reset, both enable registers read 0, the pin polarity register reads 0, the internal polarity register reads 0x00000007 (bit 0 touchscreen pen, bit 1 millisecond timer, bit 2 real-time clock), all latched events read 0 and wake_req is 0.
- R2: A source whose polarity bit is 1 records an event on a 0-to-1 transition and records nothing on a 1-to-0 transition.
- R3: A source whose polarity bit is 0 records an event on a 1-to-0 transition and records nothing on a 0-to-1 transition.
- R4: An event is recorded in the latched register whether or not its enable bit is set. The enabled-events register (low address bits 3) reads the latched value ANDed with the enable value, and it changes only when one of those two changes.
- R5: wake_req is 1 exactly when at least one group has a bit that is both latched and enabled. Either group alone can raise it.
- R6: Writing to the latched-event register (low address bits 2) clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing back the value just read clears all of them.
- R7: When an edge is detected in the same cycle as a write-1 clear of that bit, the bit stays set.
- R8: A source transition becomes visible in the latched register after the third rising clock edge that follows it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src | input | WIDTH | Internal peripheral event lines |
| pin_src | input | WIDTH | External pin event lines |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Group select (bit 2) and register select (bits 1:0) |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data for bus_addr |
| wake_req | output | 1 | Wake request, OR of all enabled latched events |

## Verification
A source change reaches the latched register three rising edges after it is driven: two synchroniser edges and one capture edge. The bench therefore drives sources just after a falling edge, counts three rising edges and samples at the following falling edge. The latency case also samples after only two edges to confirm nothing is visible yet. Register writes land on the first rising edge after the strobe. Read data and wake_req are combinational, so each is sampled at the falling edge after the state they depend on was captured. The set-beats-clear case places its write strobe over the exact cycle in which the synchronised edge is detected.

// File: rtl/wake_pkg.sv
package wake_pkg;

    // Register select carried in the low address bits
    typedef enum logic [1:0] {
        REG_ENABLE   = 2'd0,
        REG_POLARITY = 2'd1,
        REG_LATCHED  = 2'd2,
        REG_ENABLED  = 2'd3
    } wk_reg_e;

    localparam int unsigned WK_ADDR_W = 3;
    localparam logic        WK_GRP_INT = 1'b0;
    localparam logic        WK_GRP_PIN = 1'b1;

    // Internal group polarity after reset: pen, ms timer, RTC rise
    localparam int unsigned WK_BIT_PEN   = 0;
    localparam int unsigned WK_BIT_MSTMR = 1;
    localparam int unsigned WK_BIT_RTC   = 2;

endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stage_d[s] = d_i;
        end else begin : g_next
            always_comb stage_d[s] = stage_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/wk_group.sv
module wk_group
    import wake_pkg::*;
#(
    parameter int unsigned      WIDTH   = 32,
    parameter int unsigned      STAGES  = 2,
    parameter logic [WIDTH-1:0] POL_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src_i,
    input  logic             wr_en_i,
    input  wk_reg_e          wr_sel_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] en_o,
    output logic [WIDTH-1:0] pol_o,
    output logic [WIDTH-1:0] raw_o,
    output logic [WIDTH-1:0] set_o
);

    typedef struct packed {
        logic [WIDTH-1:0] en;
        logic [WIDTH-1:0] pol;
        logic [WIDTH-1:0] raw;
        logic [WIDTH-1:0] prev;
    } grp_state_t;

    grp_state_t       st_d, st_q;
    logic [WIDTH-1:0] src_sync;
    logic [WIDTH-1:0] rise, fall, hit, clr;

    wk_sync #(
        .WIDTH (WIDTH),
        .STAGES(STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (src_i),
        .q_o  (src_sync)
    );

    always_comb begin
        st_d = st_q;
        rise = src_sync & ~st_q.prev;
        fall = ~src_sync & st_q.prev;
        hit  = (st_q.pol & rise) | (~st_q.pol & fall);
        clr  = '0;
        st_d.prev = src_sync;
        if (wr_en_i) begin
            unique case (wr_sel_i)
                REG_ENABLE:   st_d.en  = wr_data_i;
                REG_POLARITY: st_d.pol = wr_data_i;
                REG_LATCHED:  clr      = wr_data_i;
                default:      ;
            endcase
        end
        // a fresh event outranks a clear in the same cycle
        st_d.raw = (st_q.raw & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en   <= '0;
            st_q.pol  <= POL_RST;
            st_q.raw  <= '0;
            st_q.prev <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign pol_o = st_q.pol;
    assign raw_o = st_q.raw;
    assign set_o = hit;

endmodule

// File: rtl/wake_latch_unit.sv
module wake_latch_unit
    import wake_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDTH-1:0]     int_src,
    input  logic [WIDTH-1:0]     pin_src,
    input  logic                 bus_wr,
    input  logic [WK_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]     bus_wdata,
    output logic [WIDTH-1:0]     bus_rdata,
    output logic                 wake_req
);

    localparam logic [WIDTH-1:0] INT_POL_RST =
        (WIDTH'(1) << WK_BIT_PEN) | (WIDTH'(1) << WK_BIT_MSTMR) | (WIDTH'(1) << WK_BIT_RTC);
    localparam logic [WIDTH-1:0] PIN_POL_RST = '0;

    wk_reg_e          sel;
    logic             grp;
    logic             wr_int, wr_pin;
    logic [WIDTH-1:0] int_en, int_pol, int_raw, int_set;
    logic [WIDTH-1:0] pin_en, pin_pol, pin_raw, pin_set;
    logic [WIDTH-1:0] int_msk, pin_msk;

    always_comb begin
        sel    = wk_reg_e'(bus_addr[1:0]);
        grp    = bus_addr[2];
        wr_int = bus_wr && (grp == WK_GRP_INT);
        wr_pin = bus_wr && (grp == WK_GRP_PIN);
    end

    wk_group #(
        .WIDTH  (WIDTH),
        .STAGES (STAGES),
        .POL_RST(INT_POL_RST)
    ) u_int_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (int_src),
        .wr_en_i  (wr_int),
        .wr_sel_i (sel),
        .wr_data_i(bus_wdata),
        .en_o     (int_en),
        .pol_o    (int_pol),
        .raw_o    (int_raw),
        .set_o    (int_set)
    );

    wk_group #(
        .WIDTH  (WIDTH),
        .STAGES (STAGES),
        .POL_RST(PIN_POL_RST)
    ) u_pin_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (pin_src),
        .wr_en_i  (wr_pin),
        .wr_sel_i (sel),
        .wr_data_i(bus_wdata),
        .en_o     (pin_en),
        .pol_o    (pin_pol),
        .raw_o    (pin_raw),
        .set_o    (pin_set)
    );

    always_comb begin
        int_msk  = int_raw & int_en;
        pin_msk  = pin_raw & pin_en;
        wake_req = (|int_msk) | (|pin_msk);
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_ENABLE:   bus_rdata = grp ? pin_en  : int_en;
            REG_POLARITY: bus_rdata = grp ? pin_pol : int_pol;
            REG_LATCHED:  bus_rdata = grp ? pin_raw : int_raw;
            REG_ENABLED:  bus_rdata = grp ? pin_msk : int_msk;
            default:      bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wake_latch_chk.sv
module wake_latch_chk
    import wake_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [WK_ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]     bus_wdata,
    input logic                 wake_req,
    input logic [WIDTH-1:0]     int_en,
    input logic [WIDTH-1:0]     pin_en,
    input logic [WIDTH-1:0]     int_raw,
    input logic [WIDTH-1:0]     pin_raw,
    input logic [WIDTH-1:0]     int_set,
    input logic [WIDTH-1:0]     pin_set
);

    assert_event_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_set != '0) |=> ((int_raw & $past(int_set)) == $past(int_set)));

    assert_raw_rise_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_raw & ~$past(pin_raw) & ~$past(pin_set)) == '0));

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == {WK_GRP_INT, REG_LATCHED})
        |=> ((int_raw & $past(bus_wdata) & ~$past(int_set)) == '0));

    assert_wake_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (int_en != '0 || pin_en != '0));

    assert_enabled_event_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_set & pin_en) != '0) && !bus_wr) |=> wake_req);

    assert_enable_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr[1:0] == REG_ENABLE) |=> ($stable(int_en) && $stable(pin_en)));

endmodule

bind wake_latch_unit wake_latch_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .wake_req (wake_req),
    .int_en   (int_en),
    .pin_en   (pin_en),
    .int_raw  (int_raw),
    .pin_raw  (pin_raw),
    .int_set  (int_set),
    .pin_set  (pin_set)
);

// File: tb/wake_latch_unit_bench.sv
module wake_latch_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    localparam logic [2:0] A_INT_EN  = 3'd0;
    localparam logic [2:0] A_INT_POL = 3'd1;
    localparam logic [2:0] A_INT_RAW = 3'd2;
    localparam logic [2:0] A_INT_MSK = 3'd3;
    localparam logic [2:0] A_PIN_EN  = 3'd4;
    localparam logic [2:0] A_PIN_POL = 3'd5;
    localparam logic [2:0] A_PIN_RAW = 3'd6;
    localparam logic [2:0] A_PIN_MSK = 3'd7;

    typedef struct packed {
        logic [W-1:0] pol;
        logic [W-1:0] en;
        logic [W-1:0] src_a;
        logic [W-1:0] src_b;
        logic [W-1:0] exp_raw;
        logic [W-1:0] exp_msk;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{pol: 32'hFFFF_FFFF, en: 32'h0000_0000, src_a: 32'h0000_0000, src_b: 32'h0000_00F0,
          exp_raw: 32'h0000_00F0, exp_msk: 32'h0000_0000},
        '{pol: 32'hFFFF_FFFF, en: 32'h0000_00F0, src_a: 32'h0000_00F0, src_b: 32'h0000_0000,
          exp_raw: 32'h0000_0000, exp_msk: 32'h0000_0000},
        '{pol: 32'h0000_0000, en: 32'hFFFF_FFFF, src_a: 32'h0000_FF00, src_b: 32'h0000_0F00,
          exp_raw: 32'h0000_F000, exp_msk: 32'h0000_F000},
        '{pol: 32'h0000_0000, en: 32'hFFFF_FFFF, src_a: 32'h0000_0000, src_b: 32'h0000_0001,
          exp_raw: 32'h0000_0000, exp_msk: 32'h0000_0000},
        '{pol: 32'h0000_FFFF, en: 32'h0001_0001, src_a: 32'h0001_0000, src_b: 32'h0000_0001,
          exp_raw: 32'h0001_0001, exp_msk: 32'h0001_0001},
        '{pol: 32'hAAAA_AAAA, en: 32'h0000_FFFF, src_a: 32'h0000_0000, src_b: 32'hFFFF_FFFF,
          exp_raw: 32'hAAAA_AAAA, exp_msk: 32'h0000_AAAA}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] int_src = '0;
    logic [W-1:0] pin_src = '0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         wake_req;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_latch_unit #(.WIDTH(W)) u_wake_latch_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_src  (int_src),
        .pin_src  (pin_src),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .wake_req (wake_req)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check_reg(input string req, input logic [2:0] a, input logic [W-1:0] exp);
        logic [W-1:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic check_wake(input string req, input logic exp);
        @(negedge clk);
        check(req, {{(W-1){1'b0}}, wake_req}, {{(W-1){1'b0}}, exp});
    endtask

    task automatic drive_int(input logic [W-1:0] v);
        @(negedge clk);
        int_src = v;
        repeat (3) @(posedge clk);
    endtask

    task automatic drive_pin(input logic [W-1:0] v);
        @(negedge clk);
        pin_src = v;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check_reg("R1 int enable", A_INT_EN, '0);
        check_reg("R1 pin enable", A_PIN_EN, '0);
        check_reg("R1 int polarity", A_INT_POL, 32'h0000_0007);
        check_reg("R1 pin polarity", A_PIN_POL, '0);
        check_reg("R1 int latched", A_INT_RAW, '0);
        check_reg("R1 pin latched", A_PIN_RAW, '0);
        check_wake("R1 wake", 1'b0);

        // R3 pins default to falling edge: rising ignored
        drive_pin('1);
        check_reg("R3 pin rise ignored", A_PIN_RAW, '0);
        wr(A_PIN_EN, 32'h0000_0008);
        drive_pin(32'hFFFF_FFF7);
        check_reg("R3 pin fall latched", A_PIN_RAW, 32'h0000_0008);
        check_reg("R4 pin enabled view", A_PIN_MSK, 32'h0000_0008);
        check_wake("R5 pin group alone wakes", 1'b1);
        wr(A_PIN_RAW, 32'h0000_0008);
        check_wake("R5 wake drops after clear", 1'b0);

        // R8 latency: internal bit0 rises, polarity 1 after reset
        @(negedge clk);
        bus_addr = A_INT_RAW;
        int_src = 32'h0000_0001;
        repeat (2) @(posedge clk);
        #1 check("R8 not yet after two edges", bus_rdata, '0);
        @(posedge clk);
        #1 check("R8 latched after three edges", bus_rdata, 32'h0000_0001);
        check_wake("R4 disabled event no wake", 1'b0);
        wr(A_INT_EN, 32'h0000_0001);
        check_wake("R5 internal group wakes", 1'b1);

        // Table walk: R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            wr(A_INT_EN, '0);
            wr(A_INT_POL, VECS[i].pol);
            drive_int(VECS[i].src_a);
            repeat (2) @(posedge clk);
            wr(A_INT_RAW, '1);
            wr(A_INT_EN, VECS[i].en);
            drive_int(VECS[i].src_b);
            check_reg($sformatf("R2/R3 vec%0d latched", i), A_INT_RAW, VECS[i].exp_raw);
            check_reg($sformatf("R4 vec%0d enabled", i), A_INT_MSK, VECS[i].exp_msk);
            check_wake($sformatf("R5 vec%0d wake", i), VECS[i].exp_msk != '0);
        end

        // R6 partial and read-back clear
        wr(A_INT_EN, '0);
        wr(A_INT_POL, '0);
        drive_int(32'h0000_FFFF);
        repeat (2) @(posedge clk);
        wr(A_INT_RAW, '1);
        drive_int(32'h0000_0FFF);
        check_reg("R6 setup", A_INT_RAW, 32'h0000_F000);
        wr(A_INT_RAW, 32'h0000_3000);
        check_reg("R6 partial clear", A_INT_RAW, 32'h0000_C000);
        rd(A_INT_RAW, v);
        wr(A_INT_RAW, v);
        check_reg("R6 read-back clear", A_INT_RAW, '0);

        // R7 set beats clear in the same cycle
        wr(A_INT_POL, '1);
        drive_int('0);
        repeat (2) @(posedge clk);
        wr(A_INT_RAW, '1);
        drive_int(32'h0000_0002);
        check_reg("R7 setup", A_INT_RAW, 32'h0000_0002);
        @(negedge clk);
        int_src = 32'h0000_0003;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_INT_RAW; bus_wdata = 32'h0000_0003;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        check_reg("R7 set wins over clear", A_INT_RAW, 32'h0000_0001);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule